// File: doc/BRIEF.md
# Phase Recovery Fence Averaging Sequencer

This block runs one fence-training pass on a PHY phase-recovery engine and turns the result into a fence setting. A single `start` pulse begins the pass. The block seeds three phase-recovery registers with a 5-bit value and raises a training-enable bit in a PHY control register. It then holds that bit for a programmable number of clocks and drops it again. After that it reads back the nine 7-bit phase values the engine recovered and takes their average, rounded up. It subtracts a fixed offset of 8 and merges the 5-bit result into the fence field of a fence control register. That merge is a read-modify-write, so the other bits of the register are kept.

As its last step the block reads the address/command timing register and writes the same value back. This re-applies the PHY's address/command delays. Every register access goes over a simple synchronous register port, and only one access is in flight at any time. A write takes one cycle. A read stays outstanding until the PHY returns `bus_rvalid`. When the pass completes, the block holds the fence value and an underflow flag on its outputs until the next pass starts.

Top module: `fence_seq`

## Requirements
- R1: After `start`, the first three accesses are writes. The first goes to address 0x050 and the second to 0x051, each with the seed in bits 4:0 of every byte and zeros elsewhere. The third goes to 0x052 with the seed in bits 4:0 only, and every other bit is zero.
- R2: The control register at 0x008 is read and then written back with bit 3 set. The block waits at least `wait_len` clocks (a value of 0 counts as 1), reads the register again, and writes it back with bit 3 cleared. All other bits are kept as read.
- R3: After bit 3 is cleared, the block reads 0x050, 0x051 and 0x052 in that order. The sum it forms uses bits 6:0 of all four bytes of the first two words and bits 6:0 of byte 0 of the third word. Bit 7 of every byte and bytes 1 to 3 of the third word have no effect.
- R4: The average is the sum divided by 9, plus one when the division leaves a remainder.
- R5: When the average is 8 or more, `fence_val` is the low 5 bits of (average − 8) and `underflow` is 0. When the average is below 8, `fence_val` is 0 and `underflow` is 1.
- R6: The block reads the fence register at 0x00C and writes it back with bits 20:16 replaced by `fence_val`. All other bits are unchanged.
- R7: The last two accesses of a pass are a read of 0x004 and a write of exactly the value that was read.
- R8: A pass makes exactly 14 accesses. No new request is issued while a read is waiting for `bus_rvalid`.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a single-cycle pulse, and `busy` is low in the cycle after it. `fence_val` and `underflow` hold their values until the next pass.
- R10: A `start` pulse that arrives while `busy` is high is ignored, and no extra accesses follow.
- R11: After reset, `busy`, `done`, `bus_req`, `fence_val` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (accepted when idle) |
| seed | input | SEED_W (5) | Seed written to the recovery registers |
| wait_len | input | WAIT_W (16) | Clocks to hold the training enable |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| fence_val | output | FENCE_W (5) | Fence value written in the last pass |
| underflow | output | 1 | Average was below the offset |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (12) | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read response valid |
| bus_rdata | input | 32 | Read response data |

## Verification
The bench builds the block with its default register map, a 16-bit wait length and the 5-bit fence field at bits 20:16. A responder with a latency of one to three cycles models the PHY. The bench sweeps the recovered-value sum over every value from 0 to 1143, which covers every average from 0 to 127. That range brings in the underflow boundary at 7/8, exact multiples of 9 against sums with a remainder, and the 5-bit wrap of large results. Across the sweep the bench also varies the seed, uses wait lengths of 0 to 5 plus one run at 200, and sets junk in the masked bits.

// File: rtl/fence_pkg.sv
// Package: shared constants and the sequencer step type.
// Assumes the PHY packs recovered phases as 7-bit fields, one per byte.
package fence_pkg;
    localparam int FIELD_W    = 7;
    localparam int NUM_FIELDS = 9;
    localparam int SUM_W      = $clog2(NUM_FIELDS * ((1 << FIELD_W) - 1) + 1);

    typedef enum logic [4:0] {
        ST_IDLE, ST_SEED0, ST_SEED1, ST_SEED2,
        ST_CTL_RD, ST_CTL_SET, ST_WAIT, ST_CTL_RD2, ST_CTL_CLR,
        ST_RB0, ST_RB1, ST_RB2,
        ST_FEN_RD, ST_FEN_WR, ST_AC_RD, ST_AC_WR, ST_DONE
    } fence_step_e;
endpackage

// File: rtl/fence_lane_sum.sv
// Adds the low FIELD_W bits of each byte of a word, over LANES bytes.
// Assumes LANES <= 4 and OUT_W is wide enough for the total.
module fence_lane_sum #(
    parameter int LANES   = 4,
    parameter int FIELD_W = 7,
    parameter int OUT_W   = 11
) (
    input  logic [8*LANES-1:0] word,
    output logic [OUT_W-1:0]   total
);
    logic [OUT_W-1:0] part [LANES+1];

    assign part[0] = '0;
    // One adder per lane, chained.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign part[g+1] = part[g] + OUT_W'(word[8*g +: FIELD_W]);
    end
    assign total = part[LANES];
endmodule

// File: rtl/fence_avg.sv
// Rounded-up divide-by-nine of the field sum, minus a fixed offset,
// clamped at zero with an underflow flag and truncated to FENCE_W bits.
// Assumes sum is stable while its result is being consumed.
module fence_avg
    import fence_pkg::*;
#(
    parameter int FENCE_W = 5,
    parameter int OFFSET  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SUM_W-1:0]   sum,
    output logic [FENCE_W-1:0] res,
    output logic               uf
);
    logic [SUM_W-1:0] avg;

    // Ceiling division and offset removal.
    always_comb begin
        avg = SUM_W'((32'(sum) + 32'(NUM_FIELDS - 1)) / 32'(NUM_FIELDS));
        if (32'(avg) < 32'(OFFSET)) begin
            res = '0;
            uf  = 1'b1;
        end else begin
            res = FENCE_W'(32'(avg) - 32'(OFFSET));
            uf  = 1'b0;
        end
    end

    // R4
    ceil_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(avg) * 32'(NUM_FIELDS) >= 32'(sum)) &&
        ((avg == '0) || ((32'(avg) - 1) * 32'(NUM_FIELDS) < 32'(sum))));
endmodule

// File: rtl/fence_wait_timer.sv
// Down-counter that times the training-enable window.
// Assumes load is a one-cycle pulse; a length of zero is treated as one.
module fence_wait_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] len,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= (len == '0) ? WAIT_W'(1) : len;
        else if (cnt != '0)        cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == WAIT_W'(1));

    // R2
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/fence_seq.sv
// Fence-training sequencer: seeds the phase-recovery registers, pulses the
// training enable for wait_len clocks, averages the nine recovered fields
// and merges the result into the fence field. Assumes the register port
// accepts a write in the cycle bus_req is high and answers each read with
// exactly one bus_rvalid cycle some time later.
module fence_seq
    import fence_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                SEED_W     = 5,
    parameter int                WAIT_W     = 16,
    parameter int                FENCE_W    = 5,
    parameter int                FENCE_LSB  = 16,
    parameter int                OFFSET     = 8,
    parameter int                TRAIN_BIT  = 3,
    parameter logic [ADDR_W-1:0] REC0_ADDR  = 12'h050,
    parameter logic [ADDR_W-1:0] REC1_ADDR  = 12'h051,
    parameter logic [ADDR_W-1:0] REC2_ADDR  = 12'h052,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h008,
    parameter logic [ADDR_W-1:0] FENCE_ADDR = 12'h00C,
    parameter logic [ADDR_W-1:0] AC_ADDR    = 12'h004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SEED_W-1:0]  seed,
    input  logic [WAIT_W-1:0]  wait_len,
    output logic               busy,
    output logic               done,
    output logic [FENCE_W-1:0] fence_val,
    output logic               underflow,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [31:0]        bus_wdata,
    input  logic               bus_rvalid,
    input  logic [31:0]        bus_rdata
);
    localparam logic [31:0] TRAIN_MASK = 32'(1) << TRAIN_BIT;
    localparam logic [31:0] FENCE_MASK = ((32'(1) << FENCE_W) - 1) << FENCE_LSB;

    fence_step_e        st;
    logic               pend;
    logic [SEED_W-1:0]  seed_q;
    logic [31:0]        rd_q;
    logic [SUM_W-1:0]   sum_q;
    logic [FENCE_W-1:0] res_q;
    logic               uf_q;
    logic [SUM_W-1:0]   lane4_sum;
    logic [SUM_W-1:0]   lane1_sum;
    logic [FENCE_W-1:0] avg_res;
    logic               avg_uf;
    logic               wait_done;
    logic               is_rd;
    logic               is_wr;
    logic               captured;
    logic [7:0]         seed_byte;

    fence_lane_sum #(.LANES(4), .FIELD_W(FIELD_W), .OUT_W(SUM_W)) u_sum4 (
        .word(bus_rdata), .total(lane4_sum));
    fence_lane_sum #(.LANES(1), .FIELD_W(FIELD_W), .OUT_W(SUM_W)) u_sum1 (
        .word(bus_rdata[7:0]), .total(lane1_sum));
    fence_avg #(.FENCE_W(FENCE_W), .OFFSET(OFFSET)) u_avg (
        .clk(clk), .rst_n(rst_n), .sum(sum_q), .res(avg_res), .uf(avg_uf));
    fence_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(st == ST_CTL_SET),
        .len(wait_len), .expired(wait_done));

    // Classify the current step as a read, a write or neither.
    always_comb begin
        is_rd = st inside {ST_CTL_RD, ST_CTL_RD2, ST_RB0, ST_RB1, ST_RB2,
                           ST_FEN_RD, ST_AC_RD};
        is_wr = st inside {ST_SEED0, ST_SEED1, ST_SEED2, ST_CTL_SET,
                           ST_CTL_CLR, ST_FEN_WR, ST_AC_WR};
        captured = is_rd && pend && bus_rvalid;
    end

    // Step sequencing, read capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pend   <= 1'b0;
            seed_q <= '0;
            rd_q   <= '0;
            sum_q  <= '0;
            res_q  <= '0;
            uf_q   <= 1'b0;
        end else begin
            if (is_rd && !pend) pend <= 1'b1;
            if (captured) begin
                pend <= 1'b0;
                rd_q <= bus_rdata;
            end
            case (st)
                ST_IDLE: if (start) begin
                    seed_q <= seed;
                    sum_q  <= '0;
                    st     <= ST_SEED0;
                end
                ST_SEED0:   st <= ST_SEED1;
                ST_SEED1:   st <= ST_SEED2;
                ST_SEED2:   st <= ST_CTL_RD;
                ST_CTL_RD:  if (captured) st <= ST_CTL_SET;
                ST_CTL_SET: st <= ST_WAIT;
                ST_WAIT:    if (wait_done) st <= ST_CTL_RD2;
                ST_CTL_RD2: if (captured) st <= ST_CTL_CLR;
                ST_CTL_CLR: st <= ST_RB0;
                ST_RB0: if (captured) begin
                    sum_q <= sum_q + lane4_sum;
                    st    <= ST_RB1;
                end
                ST_RB1: if (captured) begin
                    sum_q <= sum_q + lane4_sum;
                    st    <= ST_RB2;
                end
                ST_RB2: if (captured) begin
                    sum_q <= sum_q + lane1_sum;
                    st    <= ST_FEN_RD;
                end
                ST_FEN_RD: begin
                    if (!pend) begin
                        res_q <= avg_res;
                        uf_q  <= avg_uf;
                    end
                    if (captured) st <= ST_FEN_WR;
                end
                ST_FEN_WR:  st <= ST_AC_RD;
                ST_AC_RD:   if (captured) st <= ST_AC_WR;
                ST_AC_WR:   st <= ST_DONE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    // Drive the register port from the current step.
    always_comb begin
        seed_byte = 8'(seed_q);
        bus_req   = is_wr || (is_rd && !pend);
        bus_we    = is_wr;
        bus_addr  = '0;
        bus_wdata = '0;
        case (st)
            ST_SEED0:   begin bus_addr = REC0_ADDR; bus_wdata = {4{seed_byte}}; end
            ST_SEED1:   begin bus_addr = REC1_ADDR; bus_wdata = {4{seed_byte}}; end
            ST_SEED2:   begin bus_addr = REC2_ADDR; bus_wdata = {24'h0, seed_byte}; end
            ST_CTL_RD, ST_CTL_RD2: bus_addr = CTRL_ADDR;
            ST_CTL_SET: begin bus_addr = CTRL_ADDR; bus_wdata = rd_q | TRAIN_MASK; end
            ST_CTL_CLR: begin bus_addr = CTRL_ADDR; bus_wdata = rd_q & ~TRAIN_MASK; end
            ST_RB0:     bus_addr = REC0_ADDR;
            ST_RB1:     bus_addr = REC1_ADDR;
            ST_RB2:     bus_addr = REC2_ADDR;
            ST_FEN_RD:  bus_addr = FENCE_ADDR;
            ST_FEN_WR:  begin
                bus_addr  = FENCE_ADDR;
                bus_wdata = (rd_q & ~FENCE_MASK) | (32'(res_q) << FENCE_LSB);
            end
            ST_AC_RD:   bus_addr = AC_ADDR;
            ST_AC_WR:   begin bus_addr = AC_ADDR; bus_wdata = rd_q; end
            default:    ;
        endcase
    end

    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_DONE);
    assign fence_val = res_q;
    assign underflow = uf_q;

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> !bus_req);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fence_val) && $stable(underflow)));
    // R5
    uf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (fence_val == '0));
endmodule

// File: tb/fence_seq_bench.sv
`timescale 1ns/1ps
module fence_seq_bench;
    localparam logic [11:0] A_REC0 = 12'h050, A_REC1 = 12'h051, A_REC2 = 12'h052;
    localparam logic [11:0] A_CTRL = 12'h008, A_FEN = 12'h00C, A_AC = 12'h004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  seed = '0;
    logic [15:0] wait_len = '0;
    logic        busy, done, underflow, bus_req, bus_we;
    logic [4:0]  fence_val;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Model state
    logic [31:0] rec0, rec1, rec2, ctrl_mem, fen_init, ac_init;
    int          lat_g = 1;
    int          log_n = 0;
    logic        log_we   [32];
    logic [11:0] log_addr [32];
    logic [31:0] log_data [32];
    int          log_cyc  [32];

    fence_seq u_fence_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .wait_len(wait_len),
        .busy(busy), .done(done), .fence_val(fence_val), .underflow(underflow),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata));

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        case (a)
            A_REC0:  return rec0;
            A_REC1:  return rec1;
            A_REC2:  return rec2;
            A_CTRL:  return ctrl_mem;
            A_FEN:   return fen_init;
            A_AC:    return ac_init;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // PHY responder and access log, active on the falling edge.
    initial begin
        int          cnt = 0;
        logic [31:0] held = '0;
        forever begin
            @(negedge clk);
            bus_rvalid = 1'b0;
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) begin
                    bus_rvalid = 1'b1;
                    bus_rdata  = held;
                end
            end
            if (rst_n && bus_req) begin
                if (log_n < 32) begin
                    log_we[log_n]   = bus_we;
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                    log_cyc[log_n]  = cyc;
                end
                log_n++;
                if (bus_we) begin
                    if (bus_addr == A_CTRL) ctrl_mem = bus_wdata;
                end else begin
                    cnt  = lat_g;
                    held = model_rd(bus_addr);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_acc(input string tag, input int i, input logic we,
                           input logic [11:0] a, input logic [31:0] d, input bit cmp_d);
        chk({tag, " access kind/address"}, {19'h0, log_we[i], log_addr[i]}, {19'h0, we, a});
        if (cmp_d) chk({tag, " write data"}, log_data[i], d);
    endtask

    task automatic run_case(input logic [4:0] sd, input logic [15:0] wl,
                            input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input int lat, input bit poke,
                            input int sum_exp);
        int          guard;
        int          avg;
        logic [4:0]  res_e;
        logic        uf_e;
        logic [31:0] ctrl0, seed_rep;
        int          wmin;
        rec0 = w0; rec1 = w1; rec2 = w2;
        ctrl0    = 32'h1234_5670 ^ {16'h0, sum_exp[15:0]};
        ctrl_mem = ctrl0;
        fen_init = 32'h9E37_79B9 * (sum_exp + 1);
        ac_init  = 32'h0F1E_2D3C ^ {sum_exp[15:0], 16'h0};
        lat_g    = lat;
        log_n    = 0;
        @(negedge clk);
        seed = sd; wait_len = wl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", {31'h0, busy}, 32'h1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            seed  = ~sd;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 done pulse reached", {31'h0, done}, 32'h1);
        @(negedge clk);
        chk("R9 done single cycle / busy low", {30'h0, done, busy}, 32'h0);
        // expected result from the requirements
        avg   = (sum_exp + 8) / 9;
        uf_e  = (avg < 8);
        res_e = uf_e ? 5'd0 : 5'(avg - 8);
        if (uf_e) chk("R5 underflow clamp", {26'h0, underflow, fence_val}, {26'h0, 1'b1, 5'd0});
        else      chk("R4 R5 fence value", {26'h0, underflow, fence_val}, {26'h0, 1'b0, res_e});
        chk(poke ? "R10 access count with extra start" : "R8 access count", log_n, 14);
        if (log_n == 14) begin
            seed_rep = {4{3'b000, sd}};
            chk_acc("R1 seed rec0", 0, 1'b1, A_REC0, seed_rep, 1'b1);
            chk_acc("R1 seed rec1", 1, 1'b1, A_REC1, seed_rep, 1'b1);
            chk_acc("R1 seed rec2", 2, 1'b1, A_REC2, {27'h0, sd}, 1'b1);
            chk_acc("R2 ctrl read", 3, 1'b0, A_CTRL, 0, 1'b0);
            chk_acc("R2 enable set", 4, 1'b1, A_CTRL, ctrl0 | 32'h8, 1'b1);
            chk_acc("R2 ctrl reread", 5, 1'b0, A_CTRL, 0, 1'b0);
            chk_acc("R2 enable clear", 6, 1'b1, A_CTRL, (ctrl0 | 32'h8) & ~32'h8, 1'b1);
            wmin = (wl == 0) ? 1 : int'(wl);
            chk("R2 enable window length", {31'h0, ((log_cyc[6] - log_cyc[4]) >= wmin)}, 32'h1);
            chk_acc("R3 readback rec0", 7, 1'b0, A_REC0, 0, 1'b0);
            chk_acc("R3 readback rec1", 8, 1'b0, A_REC1, 0, 1'b0);
            chk_acc("R3 readback rec2", 9, 1'b0, A_REC2, 0, 1'b0);
            chk_acc("R6 fence read", 10, 1'b0, A_FEN, 0, 1'b0);
            chk_acc("R6 fence merge", 11, 1'b1, A_FEN,
                    (fen_init & ~32'h001F_0000) | ({27'h0, res_e} << 16), 1'b1);
            chk_acc("R7 addr/cmd read", 12, 1'b0, A_AC, 0, 1'b0);
            chk_acc("R7 addr/cmd rewrite", 13, 1'b1, A_AC, ac_init, 1'b1);
        end
        repeat (2) @(negedge clk);
        chk("R9 result held", {26'h0, underflow, fence_val}, {26'h0, uf_e, res_e});
        chk("R10 no access after done", log_n, 14);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int f [9];
        int rem;
        logic [31:0] w0, w1, w2;
        logic [7:0]  jb;
        repeat (3) @(negedge clk);
        chk("R11 reset state", {27'h0, busy, done, bus_req, underflow, 1'b0} | {27'h0, fence_val},
            32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {29'h0, busy, done, bus_req}, 32'h0);
        // Sweep every reachable sum of nine 7-bit fields.
        for (int s = 0; s <= 1143; s++) begin
            rem = s;
            for (int i = 0; i < 9; i++) begin
                f[i] = (rem > 127) ? 127 : rem;
                rem -= f[i];
            end
            jb = (s % 2 == 1) ? 8'h80 : 8'h00;
            w0 = {jb | 8'(f[3]), jb | 8'(f[2]), jb | 8'(f[1]), jb | 8'(f[0])};
            w1 = {jb | 8'(f[7]), jb | 8'(f[6]), jb | 8'(f[5]), jb | 8'(f[4])};
            w2 = {24'hC3A55A ^ 24'(s), jb | 8'(f[8])};
            run_case(5'(s * 7 + 3), 16'(s % 6), w0, w1, w2, 1 + (s % 3), 1'b0, s);
        end
        // Recommended seed with a full-length enable window.
        run_case(5'd19, 16'd200, 32'h1313_1313, 32'h1313_1313, 32'hFFFF_FF13, 2, 1'b0, 171);
        // Start while busy is ignored.
        run_case(5'd9, 16'd4, 32'h0A0A_0A0A, 32'h0A0A_0A0A, 32'h0000_000A, 1, 1'b1, 90);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule